// File: doc/BRIEF.md
# BCH-8 Sector Error Fixer

This block finishes the correction of one 512-byte sector after an 8-error BCH decoder has produced its result. The decoder's outcome arrives as three 32-bit location words and a 32-bit status word. The status word carries the error count and the top eight bits of the 104-bit location vector. The sector buffer, followed by its 13 stored ECC bytes, sits behind a synchronous single-port byte memory that the block drives.

A one-cycle start pulse launches the work. For a count from 1 to 8, the block unpacks eight 13-bit locations and adjusts each one. It then flips the addressed bit of every location that falls inside the data area, using a read followed by a write. For a count above 8, it first checks whether the page is simply erased. It counts the zero bits across the data and ECC bytes. If there are few enough, it rewrites the data to all ones. Otherwise it declares the sector uncorrectable. A one-cycle done pulse returns the result.

Top module: `bchfix_corrector`

## Requirements
- R1: A start pulse is accepted only while the block is idle. A start seen while busy has no effect on the ongoing job or its result. Completion is a one-cycle `done_o` pulse, with `fixed_cnt_o` and `uncorr_o` valid in that cycle.
- R2: The error count is taken from `status_i[13:10]`. A count of 0 gives `done_o` in the cycle after start, with zero corrections, not uncorrectable, and no memory write.
- R3: The location vector is `{status_i[23:16], word2_i, word1_i, word0_i}` (bit 103 down to bit 0). Location k is vector bits 13k+12 down to 13k.
- R4: Each location is XORed with 3 before use. The result L flips bit L mod 8 of memory byte L div 8 through a read-modify-write, and leaves the other seven bits of that byte unchanged.
- R5: An adjusted location of SECTOR_BYTES*8 (4096) or more is skipped and not counted. The ECC bytes at addresses SECTOR_BYTES to SECTOR_BYTES+12 are never written.
- R6: For a count n from 1 to 8, locations 0 to n-1 are applied in ascending order, and locations n and above are ignored. `fixed_cnt_o` is the number of locations applied, so a bit hit twice ends unchanged but counts twice.
- R7: A count above 8 starts an erased-page check. It totals the zero bits over data bytes 0 to SECTOR_BYTES-1 and all ECC bytes.
- R8: If that total is 8 or less, every data byte becomes 0xFF and the ECC bytes are left untouched. `fixed_cnt_o` is then the number of zero bits that were found in the data bytes, and `uncorr_o` is 0.
- R9: If that total exceeds 8, `uncorr_o` is 1, `fixed_cnt_o` is 0, and the memory is left unchanged.
- R10: The memory port is synchronous. A read (`mem_en_o`=1, `mem_we_o`=0) returns its byte on `mem_rdata_i` in the next cycle.
- R11: After reset, `done_o`, `uncorr_o`, `fixed_cnt_o` and `mem_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse |
| word0_i | input | 32 | Location vector bits 31:0 |
| word1_i | input | 32 | Location vector bits 63:32 |
| word2_i | input | 32 | Location vector bits 95:64 |
| status_i | input | 32 | Count in 13:10, vector bits 103:96 in 23:16 |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W (10) | Byte address: data first, then ECC bytes |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the read |
| done_o | output | 1 | One-cycle completion pulse |
| fixed_cnt_o | output | 4 | Number of bits corrected |
| uncorr_o | output | 1 | Sector uncorrectable |

## Verification
The bench keeps the default parameters: a 512-byte sector and 13 ECC bytes. The skip threshold therefore sits exactly at adjusted location 4096. This puts the last data bit (4095), the first ECC bit, and locations that straddle the 32-bit word boundaries all within the directed cases. With the real 525-byte span, a full erased-page scan and rewrite stays short. It can be run clean, just under the threshold, and one zero bit over it, including a case where the ECC bytes alone tip the total.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
  // Fixed decode-result layout: eight 13-bit locations packed back to back.
  localparam int LOC_W   = 13;
  localparam int LOC_NUM = 8;
  localparam int VEC_W   = LOC_W * LOC_NUM;
  localparam int TOP_W   = VEC_W - 96;
  localparam int TOP_LSB = 16;
  localparam int CNT_LSB = 10;
  localparam int CNT_W   = 4;
  localparam logic [LOC_W-1:0] LOC_ADJ = LOC_W'(3);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_FLIP,
    ST_SCAN,
    ST_WIPE
  } state_e;
endpackage

// File: rtl/bchfix_loc_unpack.sv
module bchfix_loc_unpack
  import bchfix_pkg::*;
(
  input  logic [31:0]                     word0_i,
  input  logic [31:0]                     word1_i,
  input  logic [31:0]                     word2_i,
  input  logic [TOP_W-1:0]                top_i,
  output logic [LOC_NUM-1:0][LOC_W-1:0]   loc_o
);
  logic [VEC_W-1:0] vec;
  assign vec = {top_i, word2_i, word1_i, word0_i};

  // Slice each location and apply the fixed index adjustment.
  for (genvar k = 0; k < LOC_NUM; k++) begin : g_slice
    assign loc_o[k] = vec[k*LOC_W +: LOC_W] ^ LOC_ADJ;
  end
endmodule

// File: rtl/bchfix_zero_tally.sv
module bchfix_zero_tally #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  byte_i,
  output logic [CW-1:0] zeros_o
);
  assign zeros_o = CW'($countones(~byte_i));
endmodule

// File: rtl/bchfix_corrector.sv
module bchfix_corrector
  import bchfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int MAX_FIX      = 8,
  localparam int TOTAL_BYTES = SECTOR_BYTES + ECC_BYTES,
  localparam int ADDR_W      = $clog2(TOTAL_BYTES + 1),
  localparam int SECTOR_BITS = SECTOR_BYTES * 8,
  localparam int TALLY_W     = $clog2(2 * MAX_FIX + 1),
  localparam int KW          = $clog2(LOC_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [31:0]       word0_i,
  input  logic [31:0]       word1_i,
  input  logic [31:0]       word2_i,
  input  logic [31:0]       status_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  output logic [3:0]        fixed_cnt_o,
  output logic              uncorr_o
);
  logic unused_status;
  assign unused_status = ^{status_i[31:24], status_i[15:14], status_i[9:0]};

  logic [LOC_NUM-1:0][LOC_W-1:0] loc_w, loc_q;
  logic [CNT_W-1:0] cnt_w, cnt_q;
  state_e           state_q;
  logic [KW-1:0]    k_q;
  logic [3:0]       fixed_q;
  logic [ADDR_W-1:0] ptr_q;
  logic             rvld_q, rdat_q;
  logic [TALLY_W-1:0] total_q, dzero_q, tot_next;
  logic [3:0]       zeros;
  logic             done_q, unc_q;
  logic [3:0]       res_q;

  assign cnt_w = status_i[CNT_LSB +: CNT_W];

  bchfix_loc_unpack u_unpack (
    .word0_i (word0_i),
    .word1_i (word1_i),
    .word2_i (word2_i),
    .top_i   (status_i[TOP_LSB +: TOP_W]),
    .loc_o   (loc_w)
  );

  bchfix_zero_tally #(.W(8)) u_tally (
    .byte_i  (mem_rdata_i),
    .zeros_o (zeros)
  );

  logic [LOC_W-1:0]  cur_loc;
  logic              loc_ok, last_k, scan_issue;
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        bit_mask;

  assign cur_loc    = loc_q[k_q];
  assign loc_ok     = 32'(cur_loc) < SECTOR_BITS;
  assign last_k     = (4'(k_q) + 4'd1) == cnt_q;
  assign byte_addr  = ADDR_W'(cur_loc >> 3);
  assign bit_mask   = 8'd1 << cur_loc[2:0];
  assign scan_issue = (state_q == ST_SCAN) && (ptr_q < ADDR_W'(TOTAL_BYTES));
  assign tot_next   = total_q + TALLY_W'(zeros);

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_PROBE: begin
        mem_en_o   = loc_ok;
        mem_addr_o = byte_addr;
      end
      ST_FLIP: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = byte_addr;
        mem_wdata_o = mem_rdata_i ^ bit_mask;
      end
      ST_SCAN: begin
        mem_en_o   = scan_issue;
        mem_addr_o = ptr_q;
      end
      ST_WIPE: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q;
        mem_wdata_o = 8'hFF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      loc_q   <= '0;
      cnt_q   <= '0;
      k_q     <= '0;
      fixed_q <= '0;
      ptr_q   <= '0;
      rvld_q  <= 1'b0;
      rdat_q  <= 1'b0;
      total_q <= '0;
      dzero_q <= '0;
      done_q  <= 1'b0;
      unc_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          loc_q   <= loc_w;
          cnt_q   <= cnt_w;
          k_q     <= '0;
          fixed_q <= '0;
          ptr_q   <= '0;
          rvld_q  <= 1'b0;
          total_q <= '0;
          dzero_q <= '0;
          if (cnt_w == '0) begin
            done_q <= 1'b1;
            res_q  <= '0;
            unc_q  <= 1'b0;
          end else if (32'(cnt_w) > MAX_FIX) begin
            state_q <= ST_SCAN;
          end else begin
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (loc_ok) begin
            state_q <= ST_FLIP;
          end else if (last_k) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= fixed_q;
            unc_q   <= 1'b0;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_FLIP: begin
          fixed_q <= fixed_q + 4'd1;
          if (last_k) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= fixed_q + 4'd1;
            unc_q   <= 1'b0;
          end else begin
            k_q     <= k_q + 1'b1;
            state_q <= ST_PROBE;
          end
        end
        ST_SCAN: begin
          ptr_q  <= ptr_q + ADDR_W'(scan_issue);
          rvld_q <= scan_issue;
          rdat_q <= ptr_q < ADDR_W'(SECTOR_BYTES);
          if (rvld_q && (tot_next > TALLY_W'(MAX_FIX))) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= '0;
            unc_q   <= 1'b1;
          end else begin
            if (rvld_q) begin
              total_q <= tot_next;
              if (rdat_q) dzero_q <= dzero_q + TALLY_W'(zeros);
            end
            if (!scan_issue && !rvld_q) begin
              if (dzero_q == '0) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                res_q   <= '0;
                unc_q   <= 1'b0;
              end else begin
                state_q <= ST_WIPE;
                ptr_q   <= '0;
              end
            end
          end
        end
        ST_WIPE: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == ADDR_W'(SECTOR_BYTES - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= 4'(dzero_q);
            unc_q   <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign fixed_cnt_o = res_q;
  assign uncorr_o    = unc_q;

  AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && mem_we_o) |-> (mem_addr_o < ADDR_W'(SECTOR_BYTES))); // R5
  AST_ZERO_CNT_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && cnt_w == '0) |=> (done_o && fixed_cnt_o == '0 && !uncorr_o)); // R2
  AST_UNCORR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && uncorr_o) |-> (fixed_cnt_o == '0)); // R9
  AST_FIX_MAX: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (32'(fixed_cnt_o) <= MAX_FIX)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (state_q == ST_IDLE)); // R1
endmodule

// File: tb/tb_bchfix_corrector.sv
module tb_bchfix_corrector;
  localparam int SB = 512;
  localparam int EB = 13;
  localparam int TB = SB + EB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] word0_i = '0, word1_i = '0, word2_i = '0, status_i = '0;
  logic        mem_en_o, mem_we_o;
  logic [9:0]  mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        done_o, uncorr_o;
  logic [3:0]  fixed_cnt_o;

  logic [7:0] mem [TB];
  logic [7:0] expm [TB];
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  bchfix_corrector dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .word0_i(word0_i), .word1_i(word1_i), .word2_i(word2_i), .status_i(status_i),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .fixed_cnt_o(fixed_cnt_o), .uncorr_o(uncorr_o)
  );

  // Synchronous byte memory model (R10)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < TB; i++)
      if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " mem byte"}, int'(mem[first]), int'(expm[first]));
  endtask

  task automatic fill_rand(input int seed);
    int s = seed;
    for (int i = 0; i < TB; i++) begin
      s = s * 1103515245 + 12345;
      mem[i] = s[23:16]; expm[i] = s[23:16];
    end
  endtask

  task automatic fill_ff();
    for (int i = 0; i < TB; i++) begin mem[i] = 8'hFF; expm[i] = 8'hFF; end
  endtask

  function automatic logic [31:0] mkstat(input logic [3:0] c, input logic [7:0] top);
    return {8'hA5, top, 2'b11, c, 10'h2AB};
  endfunction

  task automatic drive(input logic [7:0][12:0] raws, input logic [3:0] c);
    logic [103:0] v = raws;
    word0_i = v[31:0]; word1_i = v[63:32]; word2_i = v[95:64];
    status_i = mkstat(c, v[103:96]);
  endtask

  // Golden model of location correction
  task automatic golden(input logic [7:0][12:0] raws, input int c, output int nfix);
    nfix = 0;
    for (int k = 0; k < c; k++) begin
      int e = int'(raws[k] ^ 13'd3);
      if (e < SB * 8) begin expm[e / 8] ^= 8'(1 << (e % 8)); nfix++; end
    end
  endtask

  task automatic run(input logic [7:0][12:0] raws, input logic [3:0] c, output int lat);
    @(negedge clk);
    drive(raws, c);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0, "R11 done", int'(done_o), 0);
    chk(uncorr_o == 1'b0, "R11 uncorr", int'(uncorr_o), 0);
    chk(fixed_cnt_o == 4'd0, "R11 fixed", int'(fixed_cnt_o), 0);
    chk(mem_en_o == 1'b0, "R11 mem_en", int'(mem_en_o), 0);
  endtask

  task automatic t_zero_count();
    logic [7:0][12:0] r = {13'd1, 13'd2, 13'd3, 13'd4, 13'd5, 13'd6, 13'd7, 13'd8};
    int lat;
    fill_rand(11);
    run(r, 4'd0, lat);
    chk(lat == 1, "R2 latency", lat, 1);
    chk(done_o && fixed_cnt_o == 0 && !uncorr_o, "R2 result", int'(fixed_cnt_o), 0);
    cmp_mem("R2 untouched");
  endtask

  task automatic t_fix_basic();
    // locations 3..7 are junk and must be ignored with count 3
    logic [7:0][12:0] r = {13'h1555, 13'h0AAA, 13'd9, 13'd17, 13'd33,
                           13'd4000, 13'd100, 13'd0};
    int lat, nf;
    fill_rand(22);
    golden(r, 3, nf);
    run(r, 4'd3, lat);
    chk(done_o && fixed_cnt_o == nf && !uncorr_o, "R6 count3", int'(fixed_cnt_o), nf);
    cmp_mem("R4 basic flips");
  endtask

  task automatic t_fix_full8();
    // locations 2, 4 and 7 straddle word boundaries
    logic [7:0][12:0] r = {13'd2222, 13'd777, 13'd4091, 13'd5,
                           13'd3000, 13'd2047, 13'd1234, 13'd7};
    int lat, nf;
    fill_rand(33);
    golden(r, 8, nf);
    run(r, 4'd8, lat);
    chk(done_o && fixed_cnt_o == 8 && !uncorr_o, "R3 count8", int'(fixed_cnt_o), 8);
    cmp_mem("R3 unpack flips");
  endtask

  task automatic t_skip();
    logic [7:0][12:0] r = {13'd0, 13'd0, 13'd0, 13'd4096,
                           13'd4095, 13'd8191, 13'd4099, 13'd4092};
    int lat, nf;
    fill_rand(44);
    golden(r, 5, nf);
    run(r, 4'd5, lat);
    chk(done_o && fixed_cnt_o == 2 && nf == 2, "R5 skip count", int'(fixed_cnt_o), 2);
    cmp_mem("R5 ecc untouched");
  endtask

  task automatic t_same_bit();
    logic [7:0][12:0] r = {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd50, 13'd50};
    int lat, nf;
    fill_rand(55);
    golden(r, 2, nf);
    run(r, 4'd2, lat);
    chk(done_o && fixed_cnt_o == 2, "R6 twice count", int'(fixed_cnt_o), 2);
    cmp_mem("R6 twice restores");
  endtask

  task automatic t_busy_ignore();
    logic [7:0][12:0] r  = {13'd70, 13'd60, 13'd50, 13'd40, 13'd30, 13'd20, 13'd10, 13'd1};
    logic [7:0][12:0] r2 = {13'd9, 13'd9, 13'd9, 13'd9, 13'd9, 13'd9, 13'd9, 13'd9};
    int nf, lat = 0;
    fill_rand(66);
    golden(r, 8, nf);
    @(negedge clk);
    drive(r, 4'd8);
    start_i = 1'b1;
    @(negedge clk);
    drive(r2, 4'd0);          // second start while busy
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o, "R1 busy start ignored", int'(done_o), 0);
    while (!done_o && lat < 5000) begin @(negedge clk); lat++; end
    chk(done_o && fixed_cnt_o == 8, "R1 first job result", int'(fixed_cnt_o), 8);
    cmp_mem("R1 first job memory");
    @(negedge clk);
    chk(!done_o, "R1 done single pulse", int'(done_o), 0);
  endtask

  task automatic t_erased_ok();
    logic [7:0][12:0] r = '0;
    int lat;
    fill_ff();
    mem[3] = 8'hFE; mem[200] = 8'h7F; mem[511] = 8'hEF;
    mem[SB] = 8'hFD; expm[SB] = 8'hFD; mem[SB+12] = 8'hBF; expm[SB+12] = 8'hBF;
    run(r, 4'd15, lat);
    chk(done_o && fixed_cnt_o == 3 && !uncorr_o, "R8 erased fixed", int'(fixed_cnt_o), 3);
    cmp_mem("R8 wiped data");
  endtask

  task automatic t_erased_clean();
    logic [7:0][12:0] r = '0;
    int lat;
    fill_ff();
    mem[SB+5] = 8'h00; expm[SB+5] = 8'h00;   // eight zeros, ECC only
    run(r, 4'd9, lat);
    chk(done_o && fixed_cnt_o == 0 && !uncorr_o, "R7 ecc eight ok", int'(uncorr_o), 0);
    cmp_mem("R7 ecc eight memory");
  endtask

  task automatic t_erased_bad_ecc();
    logic [7:0][12:0] r = '0;
    int lat;
    fill_ff();
    mem[SB+5] = 8'h00; expm[SB+5] = 8'h00;
    mem[100] = 8'hFB; expm[100] = 8'hFB;       // ninth zero
    run(r, 4'd9, lat);
    chk(done_o && uncorr_o && fixed_cnt_o == 0, "R7 ecc counted", int'(uncorr_o), 1);
    cmp_mem("R9 unchanged");
  endtask

  task automatic t_erased_bad_data();
    logic [7:0][12:0] r = '0;
    int lat;
    fill_rand(77);
    run(r, 4'd12, lat);
    chk(done_o && uncorr_o, "R9 uncorrectable", int'(uncorr_o), 1);
    chk(fixed_cnt_o == 0, "R9 zero fixed", int'(fixed_cnt_o), 0);
    cmp_mem("R9 random unchanged");
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < TB; i++) begin mem[i] = 8'h00; expm[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_fix_basic();
    t_fix_full8();
    t_skip();
    t_same_bit();
    t_busy_ignore();
    t_erased_ok();
    t_erased_clean();
    t_erased_bad_ecc();
    t_erased_bad_data();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule